// File: doc/BRIEF.md
# Multichannel DAC Staging Register Bank

This block sits between a command source and the frame builder of a multichannel DAC that transmits a fresh frame at a regular interval. A write port carries a channel number and a sample word. A write never drives the output directly; it parks the word in a per-channel staging register and marks that channel as having a value waiting. At every frame strobe the bank decides, channel by channel, whether the waiting value is copied into the transmit register that feeds the frame.

Two masks govern that decision. A hold mask can keep a channel's waiting value back from frame to frame. A release mask frees held channels, and it clears itself on every strobe. Software can hold a set of channels, stage new values on each of them, and then release them with one write. All of them then change in the same frame. Next to each channel's value the block gives a flag that shows whether the value changed in the frame built at the last strobe.

Top module: `dac_stage_bank`

## Requirements
- R1: A data write (`wr_en`, `wr_chan`, `wr_data`) only stages the word. `dac_out` and `chg_flag` keep their values until the next `frame_strobe`.
- R2: At a strobe, every channel that has a waiting value and whose hold bit is 0 copies that value into its slice of `dac_out`. Channel n occupies bits [16n+15:16n].
- R3: At each strobe, `chg_flag` bit n is loaded with 1 if channel n was sent in that frame and with 0 otherwise. It then keeps that value until the next strobe.
- R4: A channel whose hold bit is 1 keeps its waiting value back at every strobe until its release bit is 1.
- R5: A release write ORs `upd_wr_mask` into the release mask. At the next strobe, all held channels with a waiting value whose release bit is set are sent together in that one frame.
- R6: The release mask returns to all zeros at every strobe without any further write. A release write made in the same cycle as a strobe applies only to the following frame.
- R7: If a channel is written more than once before it is sent, only the last word goes out.
- R8: A release bit set for a channel that has no waiting value gives no change flag and leaves that channel's output as it was.
- R9: A data write made in the same cycle as a strobe is staged for a later frame. The frame built at that strobe carries the value that was already waiting, if there was one.
- R10: A hold write replaces the whole hold mask, with bit n applying to channel n. The new mask applies from the next cycle.
- R11: A synchronous active-high `rst` clears all staged words, waiting flags and both masks. It also drives `dac_out` and `chg_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Stage a data word |
| wr_chan | input | 5 | Target channel of the data write |
| wr_data | input | 16 | Data word to stage |
| hold_wr_en | input | 1 | Replace the hold mask |
| hold_wr_mask | input | 32 | New hold mask, bit n is channel n |
| upd_wr_en | input | 1 | OR bits into the release mask |
| upd_wr_mask | input | 32 | Release bits, bit n is channel n |
| frame_strobe | input | 1 | Frame boundary; the frame is built at this edge |
| dac_out | output | 512 | Transmit values, channel n at [16n+15:16n] |
| chg_flag | output | 32 | Per-channel changed-in-last-frame flags |

## Verification
A frame strobe can arrive in the same cycle as a data write, and also in the same cycle as a release write. Both cases are tested on purpose. In the first, a channel already has a value waiting when the strobe and a new write arrive together. The bench expects the old word in that frame and the new word one strobe later. In the second, a held channel receives its release bit in the strobe cycle. The bench expects no flag in that frame and the release to take effect at the next strobe.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int unsigned DEF_NCH = 32;
  localparam int unsigned DEF_DW  = 16;

  // A channel may leave at a strobe when it is free, or held and released.
  function automatic logic chan_may_send(input logic held, input logic released);
    return (~held) | released;
  endfunction

  // Next release mask: cleared by a strobe, then new bits ORed in.
  function automatic logic [DEF_NCH-1:0] next_release(
      input logic [DEF_NCH-1:0] cur, input logic strobe,
      input logic wr, input logic [DEF_NCH-1:0] bits);
    logic [DEF_NCH-1:0] base;
    base = strobe ? '0 : cur;
    return wr ? (base | bits) : base;
  endfunction
endpackage

// File: rtl/dac_write_decode.sv
module dac_write_decode #(
  parameter int unsigned NCH = 32,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_chan,
  output logic [NCH-1:0] wr_sel
);
  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (wr_chan == AW'(g));
  end
endmodule

// File: rtl/dac_mask_regs.sv
module dac_mask_regs #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_wr_en,
  input  logic [NCH-1:0] hold_wr_mask,
  input  logic           upd_wr_en,
  input  logic [NCH-1:0] upd_wr_mask,
  input  logic           frame_strobe,
  output logic [NCH-1:0] hold_q,
  output logic [NCH-1:0] upd_q
);
  import dac_stage_pkg::*;

  logic [NCH-1:0] upd_d;

  always_comb begin
    upd_d = frame_strobe ? '0 : upd_q;
    if (upd_wr_en) upd_d = upd_d | upd_wr_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      upd_q  <= '0;
    end else begin
      if (hold_wr_en) hold_q <= hold_wr_mask;
      upd_q <= upd_d;
    end
  end
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_strobe,
  input  logic          held,
  input  logic          released,
  output logic          pending,
  output logic          fire,
  output logic [DW-1:0] tx_val,
  output logic          chg
);
  import dac_stage_pkg::*;

  logic [DW-1:0] staged_q;

  assign fire = frame_strobe && pending && chan_may_send(held, released);

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      pending  <= 1'b0;
      tx_val   <= '0;
      chg      <= 1'b0;
    end else begin
      if (fire) tx_val <= staged_q;
      if (frame_strobe) chg <= fire;
      if (wr_sel) begin
        staged_q <= wr_data;
        pending  <= 1'b1;
      end else if (fire) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dac_stage_bank.sv
module dac_stage_bank #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 16,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_chan,
  input  logic [DW-1:0]     wr_data,
  input  logic              hold_wr_en,
  input  logic [NCH-1:0]    hold_wr_mask,
  input  logic              upd_wr_en,
  input  logic [NCH-1:0]    upd_wr_mask,
  input  logic              frame_strobe,
  output logic [NCH*DW-1:0] dac_out,
  output logic [NCH-1:0]    chg_flag
);
  logic [NCH-1:0] wr_sel;
  logic [NCH-1:0] hold_q;
  logic [NCH-1:0] upd_q;
  logic [NCH-1:0] pending_vec;
  logic [NCH-1:0] fire_vec;

  dac_write_decode #(.NCH(NCH)) dec_i (
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_sel(wr_sel)
  );

  dac_mask_regs #(.NCH(NCH)) masks_i (
    .clk(clk), .rst(rst),
    .hold_wr_en(hold_wr_en), .hold_wr_mask(hold_wr_mask),
    .upd_wr_en(upd_wr_en), .upd_wr_mask(upd_wr_mask),
    .frame_strobe(frame_strobe),
    .hold_q(hold_q), .upd_q(upd_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_chan_slice #(.DW(DW)) slice_i (
      .clk(clk), .rst(rst),
      .wr_sel(wr_sel[g]), .wr_data(wr_data),
      .frame_strobe(frame_strobe),
      .held(hold_q[g]), .released(upd_q[g]),
      .pending(pending_vec[g]), .fire(fire_vec[g]),
      .tx_val(dac_out[g*DW +: DW]), .chg(chg_flag[g])
    );
  end
endmodule

// File: rtl/dac_stage_bank_chk.sv
module dac_stage_bank_chk #(
  parameter int unsigned NCH = 32,
  parameter int unsigned DW  = 16,
  localparam int unsigned AW = $clog2(NCH)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     wr_chan,
  input logic              upd_wr_en,
  input logic              frame_strobe,
  input logic [NCH*DW-1:0] dac_out,
  input logic [NCH-1:0]    chg_flag,
  input logic [NCH-1:0]    hold_q,
  input logic [NCH-1:0]    upd_q,
  input logic [NCH-1:0]    pending_vec
);
  // R1: the output moves only at a strobe
  a_r1_out_still: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |=> $stable(dac_out));
  // R3: the flags hold between strobes
  a_r3_flag_still: assert property (@(posedge clk) disable iff (rst)
    !frame_strobe |=> $stable(chg_flag));
  // R1: a data write leaves its channel waiting
  a_r1_write_waits: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pending_vec[$past(wr_chan)]);
  // R4: a held channel without a release bit is never flagged
  a_r4_held_quiet: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> (chg_flag & $past(hold_q & ~upd_q)) == '0);
  // R8: no flag without a waiting value
  a_r8_flag_needs_wait: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> (chg_flag & ~$past(pending_vec)) == '0);
  // R6: the release mask is empty after a strobe with no release write
  a_r6_release_clears: assert property (@(posedge clk) disable iff (rst)
    (frame_strobe && !upd_wr_en) |=> upd_q == '0);
endmodule

bind dac_stage_bank dac_stage_bank_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
  .upd_wr_en(upd_wr_en), .frame_strobe(frame_strobe),
  .dac_out(dac_out), .chg_flag(chg_flag),
  .hold_q(hold_q), .upd_q(upd_q), .pending_vec(pending_vec)
);

// File: tb/dac_stage_bank_tb_top.sv
module dac_stage_bank_tb_top;
  localparam int NCH = 32;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_chan = '0;
  logic [DW-1:0] wr_data = '0;
  logic hold_wr_en = 1'b0;
  logic [NCH-1:0] hold_wr_mask = '0;
  logic upd_wr_en = 1'b0;
  logic [NCH-1:0] upd_wr_mask = '0;
  logic frame_strobe = 1'b0;
  logic [NCH*DW-1:0] dac_out;
  logic [NCH-1:0] chg_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] last_wr [NCH];
  logic [DW-1:0] exp_out [NCH];

  always #10 clk = ~clk;

  dac_stage_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
    .hold_wr_en(hold_wr_en), .hold_wr_mask(hold_wr_mask),
    .upd_wr_en(upd_wr_en), .upd_wr_mask(upd_wr_mask),
    .frame_strobe(frame_strobe), .dac_out(dac_out), .chg_flag(chg_flag)
  );

  // op: 0 write, 1 hold, 2 release, 3 strobe
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  ch;
    logic [15:0] data;
    logic [31:0] mask;
    logic [31:0] exp_chg;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd0, 16'h1111, 32'h0, 32'h0},
    '{2'd0, 5'd1, 16'h2222, 32'h0, 32'h0},
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h3},          // R2
    '{2'd1, 5'd0, 16'h0,    32'h4, 32'h0},          // R10
    '{2'd0, 5'd2, 16'h3333, 32'h0, 32'h0},
    '{2'd0, 5'd3, 16'h4444, 32'h0, 32'h0},
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h8},          // R4
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h0},          // R4
    '{2'd0, 5'd2, 16'h5555, 32'h0, 32'h0},          // R7
    '{2'd2, 5'd0, 16'h0,    32'h24, 32'h0},         // R5 R8
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h4},          // R5 R8
    '{2'd0, 5'd2, 16'h6666, 32'h0, 32'h0},
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h0},          // R6
    '{2'd1, 5'd0, 16'h0,    32'h0, 32'h0},
    '{2'd3, 5'd0, 16'h0,    32'h0, 32'h4}           // R10
  };

  task automatic step(input bit w, input int ch, input logic [15:0] d,
                      input bit hw, input logic [31:0] hm,
                      input bit uw, input logic [31:0] um, input bit st);
    @(negedge clk);
    wr_en = w; wr_chan = 5'(ch); wr_data = d;
    hold_wr_en = hw; hold_wr_mask = hm;
    upd_wr_en = uw; upd_wr_mask = um;
    frame_strobe = st;
    @(negedge clk);
    wr_en = 0; hold_wr_en = 0; upd_wr_en = 0; frame_strobe = 0;
  endtask

  task automatic chk_flags(input logic [31:0] exp, input string tag);
    total++;
    if (chg_flag !== exp) begin
      bad++;
      $display("FAIL %s chg_flag actual=%h expected=%h", tag, chg_flag, exp);
    end
  endtask

  task automatic chk_all_outs(input string tag);
    for (int c = 0; c < NCH; c++) begin
      total++;
      if (dac_out[c*DW +: DW] !== exp_out[c]) begin
        bad++;
        $display("FAIL %s ch%0d actual=%h expected=%h", tag, c, dac_out[c*DW +: DW], exp_out[c]);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin last_wr[c] = '0; exp_out[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk_flags('0, "R11 reset flags");
    chk_all_outs("R11 reset outputs");

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: begin
          step(1, VECS[i].ch, VECS[i].data, 0, '0, 0, '0, 0);
          last_wr[VECS[i].ch] = VECS[i].data;
          chk_all_outs("R1 write only stages");
        end
        2'd1: step(0, 0, '0, 1, VECS[i].mask, 0, '0, 0);
        2'd2: step(0, 0, '0, 0, '0, 1, VECS[i].mask, 0);
        default: begin
          step(0, 0, '0, 0, '0, 0, '0, 1);
          for (int c = 0; c < NCH; c++)
            if (VECS[i].exp_chg[c]) exp_out[c] = last_wr[c];
          chk_flags(VECS[i].exp_chg, "R2/R3 frame flags");
          chk_all_outs("R2 R4 R5 R7 R8 frame values");
        end
      endcase
    end

    // R3: flags persist without a strobe
    step(0, 0, '0, 0, '0, 0, '0, 0);
    chk_flags(32'h4, "R3 flags held");

    // R6: release written in the strobe cycle applies to the next frame
    step(0, 0, '0, 1, 32'h80, 0, '0, 0);
    step(1, 7, 16'h7777, 0, '0, 0, '0, 0);
    step(0, 0, '0, 0, '0, 1, 32'h80, 1);
    chk_flags('0, "R6 same-cycle release deferred");
    chk_all_outs("R6 held value not sent");
    step(0, 0, '0, 0, '0, 0, '0, 1);
    exp_out[7] = 16'h7777;
    chk_flags(32'h80, "R6 release next frame");
    chk_all_outs("R6 released value");

    // R9: write coinciding with strobe
    step(1, 8, 16'hAAAA, 0, '0, 0, '0, 0);
    step(1, 8, 16'hBBBB, 0, '0, 0, '0, 1);
    exp_out[8] = 16'hAAAA;
    chk_flags(32'h100, "R9 old value in frame");
    chk_all_outs("R9 old value");
    step(0, 0, '0, 0, '0, 0, '0, 1);
    exp_out[8] = 16'hBBBB;
    chk_flags(32'h100, "R9 new value next frame");
    chk_all_outs("R9 new value");

    // R11: reset mid-run
    step(1, 9, 16'hCCCC, 1, 32'hFFFF_FFFF, 1, 32'h1, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int c = 0; c < NCH; c++) exp_out[c] = '0;
    chk_flags('0, "R11 reset clears flags");
    chk_all_outs("R11 reset clears outputs");
    step(0, 0, '0, 0, '0, 0, '0, 1);
    chk_flags('0, "R11 nothing waits after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule